// File: doc/BRIEF.md
# SPI Chip-Select Generator

This block drives a bank of SPI chip-select pins (four by default) for a controller that talks to several slaves over one set of data lines. It takes its control fields from a single control word and a busy flag from the shift engine that runs the exchange. It produces registered pin levels, so the pins never glitch while the control word is being rewritten.

The control word picks a target slave with an index field and picks one of two modes. In automatic mode the busy flag frames the assertion: the target line goes to its asserted level while the exchange runs and returns to idle when it ends. The target is captured when the exchange starts, so rewriting the index mid-exchange does not move the active line. In manual mode software drives the target line's pin level directly and ignores the busy flag. A polarity bit sets which level counts as asserted. The same bit also sets the idle level of every line that is not driven, so an idle bus of active-low slaves rests high.

A three-state machine sequences the pins. ST_IDLE means automatic mode with no exchange, ST_XFER means an automatic exchange is running on the captured target, and ST_MANUAL means software control. The transitions are as follows:
- START goes from ST_IDLE to ST_XFER when busy is seen and manual mode is clear, and captures the index.
- FINISH goes from ST_XFER to ST_IDLE when busy is seen low.
- TAKEOVER goes from ST_IDLE or ST_XFER to ST_MANUAL when the manual bit is seen set.
- RELEASE_IDLE goes from ST_MANUAL to ST_IDLE when the manual bit clears and busy is low.
- RELEASE_XFER goes from ST_MANUAL to ST_XFER when the manual bit clears while busy is high, and captures the index.

Top module: `spi_cs_gen`

## Requirements
- R1: While reset is asserted (rst_ni low, asynchronous), every pin of cs_pins_o reads 0, and the machine is in ST_IDLE.
- R2: In automatic mode with busy low, on the clock edge after an input is sampled every pin equals the idle level. The idle level is 1 when control bit 4 is set and 0 when it is clear.
- R3: Each pin is a register, so a sampled input shows on the pins after one clock edge. When busy is first sampled high in automatic mode (control bit 16 clear), the line numbered by control bits [13:12] (pin index 0..3) takes the asserted level after that edge. The asserted level is the inverse of the idle level. All other lines stay idle.
- R4: When busy is sampled low during an automatic exchange, all lines return to the idle level on that same edge. The target line is therefore asserted until the cycle after the last busy cycle.
- R5: A change of control bits [13:12] while an automatic exchange is running has no effect on the pins. The captured target stays asserted until the exchange ends.
- R6: When control bit 16 is set, after the next edge the line numbered by bits [13:12] carries the pin level given by control bit 17. All other lines are idle, whatever the value of busy.
- R7: The polarity bit (control bit 4) is used as it stands on every edge. Flipping it during an exchange inverts all pins after the next edge.
- R8: If bit 16 clears while busy is high, the block enters an automatic exchange at once. It captures the index present on that edge and asserts that line after the edge.
- R9: At no time after reset does more than one pin differ from the idle level.
- R10: In manual mode the index is used as it stands on every edge. Changing it moves the driven line after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_word_i | input | CTRL_W (32) | Control word: bit 4 polarity, bits [13:12] target index, bit 16 manual mode, bit 17 manual level |
| xfer_busy_i | input | 1 | High while the shift engine runs an exchange |
| cs_pins_o | output | NUM_CS (4) | Registered chip-select pin levels |

## Verification
The checks assume the control word and busy flag are synchronous to clk_i and settle before each rising edge. They also assume the index field never names a line beyond NUM_CS-1. The bench changes every input on the falling clock edge and keeps the index within 0..3. Under these conditions each pin pattern can be predicted from the inputs of the previous edge alone.

// File: rtl/spi_cs_gen_pkg.sv
package spi_cs_gen_pkg;

    // Bit positions inside the control word, decoded by the field decoder.
    localparam int unsigned POL_BIT    = 4;
    localparam int unsigned SEL_LSB    = 12;
    localparam int unsigned MANUAL_BIT = 16;
    localparam int unsigned LEVEL_BIT  = 17;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_MANUAL = 2'd2
    } cs_state_e;

endpackage

// File: rtl/spi_cs_field_decode.sv
module spi_cs_field_decode
    import spi_cs_gen_pkg::*;
#(
    parameter int unsigned CTRL_W = 32,
    parameter int unsigned SEL_W  = 2
) (
    input  logic [CTRL_W-1:0] ctrl_word_i,
    output logic [SEL_W-1:0]  sel_idx_o,
    output logic              manual_en_o,
    output logic              manual_lvl_o,
    output logic              pol_low_o
);

    assign sel_idx_o    = ctrl_word_i[SEL_LSB +: SEL_W];
    assign manual_en_o  = ctrl_word_i[MANUAL_BIT];
    assign manual_lvl_o = ctrl_word_i[LEVEL_BIT];
    assign pol_low_o    = ctrl_word_i[POL_BIT];

endmodule

// File: rtl/spi_cs_seq_fsm.sv
module spi_cs_seq_fsm
    import spi_cs_gen_pkg::*;
#(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_idx_i,
    input  logic             manual_en_i,
    input  logic             busy_i,
    output cs_state_e        state_d_o,
    output logic [SEL_W-1:0] drive_idx_o
);

    cs_state_e        state_q, state_d;
    logic [SEL_W-1:0] tgt_q, tgt_d;

    // Next-state and target capture.
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (manual_en_i) begin
                    state_d = ST_MANUAL;                 // TAKEOVER
                end else if (busy_i) begin
                    state_d = ST_XFER;                   // START
                    tgt_d   = sel_idx_i;
                end
            end
            ST_XFER: begin
                if (manual_en_i) begin
                    state_d = ST_MANUAL;                 // TAKEOVER
                end else if (!busy_i) begin
                    state_d = ST_IDLE;                   // FINISH
                end
            end
            ST_MANUAL: begin
                if (!manual_en_i) begin
                    if (busy_i) begin
                        state_d = ST_XFER;               // RELEASE_XFER
                        tgt_d   = sel_idx_i;
                    end else begin
                        state_d = ST_IDLE;               // RELEASE_IDLE
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    assign state_d_o   = state_d;
    assign drive_idx_o = (state_d == ST_MANUAL) ? sel_idx_i : tgt_d;

endmodule

// File: rtl/spi_cs_pin_drive.sv
module spi_cs_pin_drive
    import spi_cs_gen_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned SEL_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  cs_state_e         state_d_i,
    input  logic [SEL_W-1:0]  drive_idx_i,
    input  logic              manual_lvl_i,
    input  logic              pol_low_i,
    output logic [NUM_CS-1:0] pins_o
);

    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_line
        localparam logic [SEL_W-1:0] LINE_IDX = SEL_W'(gi);
        logic line_d;
        logic line_q;

        always_comb begin
            line_d = pol_low_i;
            if (drive_idx_i == LINE_IDX) begin
                unique case (state_d_i)
                    ST_XFER:   line_d = ~pol_low_i;
                    ST_MANUAL: line_d = manual_lvl_i;
                    default:   line_d = pol_low_i;
                endcase
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                line_q <= 1'b0;
            end else begin
                line_q <= line_d;
            end
        end

        assign pins_o[gi] = line_q;
    end

endmodule

// File: rtl/spi_cs_gen.sv
module spi_cs_gen
    import spi_cs_gen_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned CTRL_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CTRL_W-1:0] ctrl_word_i,
    input  logic              xfer_busy_i,
    output logic [NUM_CS-1:0] cs_pins_o
);

    localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic [SEL_W-1:0] sel_idx;
    logic             manual_en;
    logic             manual_lvl;
    logic             pol_low;
    cs_state_e        state_d;
    logic [SEL_W-1:0] drive_idx;

    spi_cs_field_decode #(
        .CTRL_W (CTRL_W),
        .SEL_W  (SEL_W)
    ) u_decode (
        .ctrl_word_i  (ctrl_word_i),
        .sel_idx_o    (sel_idx),
        .manual_en_o  (manual_en),
        .manual_lvl_o (manual_lvl),
        .pol_low_o    (pol_low)
    );

    spi_cs_seq_fsm #(
        .SEL_W (SEL_W)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sel_idx_i   (sel_idx),
        .manual_en_i (manual_en),
        .busy_i      (xfer_busy_i),
        .state_d_o   (state_d),
        .drive_idx_o (drive_idx)
    );

    spi_cs_pin_drive #(
        .NUM_CS (NUM_CS),
        .SEL_W  (SEL_W)
    ) u_drive (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .state_d_i    (state_d),
        .drive_idx_i  (drive_idx),
        .manual_lvl_i (manual_lvl),
        .pol_low_i    (pol_low),
        .pins_o       (cs_pins_o)
    );

endmodule

// File: rtl/spi_cs_gen_checker.sv
module spi_cs_gen_checker
    import spi_cs_gen_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned CTRL_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CTRL_W-1:0] ctrl_word_i,
    input logic              xfer_busy_i,
    input logic [NUM_CS-1:0] cs_pins_o
);

    localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic [1:0] live_cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            live_cnt <= '0;
        end else if (live_cnt != 2'd3) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    logic             pol_s, man_s, lvl_s;
    logic [SEL_W-1:0] idx_s;
    assign pol_s = ctrl_word_i[POL_BIT];
    assign man_s = ctrl_word_i[MANUAL_BIT];
    assign lvl_s = ctrl_word_i[LEVEL_BIT];
    assign idx_s = ctrl_word_i[SEL_LSB +: SEL_W];

    // R9: at most one line away from the idle level
    assert_one_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || live_cnt == 2'd0)
        $countones(cs_pins_o ^ {NUM_CS{$past(pol_s)}}) <= 1);

    // R6: manual mode drives the selected line with the level bit
    assert_manual_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || live_cnt == 2'd0)
        $past(man_s) |-> (cs_pins_o[$past(idx_s)] == $past(lvl_s)));

    // R2: automatic mode without busy leaves every line idle
    assert_auto_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || live_cnt == 2'd0)
        (!$past(man_s) && !$past(xfer_busy_i)) |-> (cs_pins_o == {NUM_CS{$past(pol_s)}}));

    // R5: a running exchange keeps its pin pattern while polarity holds
    assert_target_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || live_cnt < 2'd2)
        ($past(xfer_busy_i) && $past(xfer_busy_i, 2) && !$past(man_s) && !$past(man_s, 2)
         && ($past(pol_s) == $past(pol_s, 2))) |-> (cs_pins_o == $past(cs_pins_o)));

endmodule

bind spi_cs_gen spi_cs_gen_checker #(
    .NUM_CS (NUM_CS),
    .CTRL_W (CTRL_W)
) u_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_word_i (ctrl_word_i),
    .xfer_busy_i (xfer_busy_i),
    .cs_pins_o   (cs_pins_o)
);

// File: tb/spi_cs_gen_tb_top.sv
`timescale 1ns/1ps
module spi_cs_gen_tb_top;

    localparam int NUM_CS = 4;
    localparam int CTRL_W = 32;
    localparam int NVEC   = 17;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic [CTRL_W-1:0] ctrl_word_i = '0;
    logic              xfer_busy_i = 1'b0;
    logic [NUM_CS-1:0] cs_pins_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk_i = ~clk_i;

    spi_cs_gen #(.NUM_CS(NUM_CS), .CTRL_W(CTRL_W)) dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ctrl_word_i (ctrl_word_i),
        .xfer_busy_i (xfer_busy_i),
        .cs_pins_o   (cs_pins_o)
    );

    // Row: {manual, level, pol_low, idx[1:0], busy, expected pins[3:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0000},  // 0  R2 idle low
        {1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'b1111},  // 1  R7 idle high
        {1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 4'b1011},  // 2  R3 start on line 2
        {1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 4'b1011},  // 3  R5 index change ignored
        {1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'b1111},  // 4  R4 finish
        {1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 4'b1110},  // 5  R3 new capture line 0
        {1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'b0001},  // 6  R7 polarity flip mid exchange
        {1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 4'b0000},  // 7  R4 finish
        {1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 4'b1000},  // 8  R6 manual high on line 3
        {1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 4'b0000},  // 9  R6 busy ignored in manual
        {1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 4'b1101},  // 10 R10 index moves at once
        {1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 4'b1111},  // 11 R6 level high on line 1
        {1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 4'b1101},  // 12 R8 release into exchange
        {1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 4'b1101},  // 13 R5 index change ignored
        {1'b1, 1'b1, 1'b0, 2'd2, 1'b1, 4'b0100},  // 14 R6 takeover from exchange
        {1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 4'b0100},  // 15 R8 release captures line 2
        {1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 4'b0000}   // 16 R4 finish
    };

    function automatic string vec_tag(int i);
        case (i)
            0:            return "R2";
            1, 6:         return "R7";
            2, 5:         return "R3";
            3, 13:        return "R5";
            4, 7, 16:     return "R4";
            8, 9, 11, 14: return "R6";
            10:           return "R10";
            default:      return "R8";
        endcase
    endfunction

    task automatic drive(input logic man, input logic lvl, input logic pol,
                         input logic [1:0] idx, input logic busy);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[16]    = man;
        w[17]    = lvl;
        w[4]     = pol;
        w[13:12] = idx;
        ctrl_word_i = w;
        xfer_busy_i = busy;
    endtask

    task automatic check(input logic [3:0] exp, input string tag);
        checks++;
        if (cs_pins_o !== exp) begin
            fails++;
            $display("FAIL %s: cs_pins got %b expected %b", tag, cs_pins_o, exp);
        end
    endtask

    initial begin
        // R1: reset with busy and active-low already requested
        drive(1'b0, 1'b0, 1'b1, 2'd2, 1'b1);
        repeat (3) @(negedge clk_i);
        check(4'b0000, "R1 during reset");
        drive(1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        // Table walk: drive on falling edge, check on next falling edge.
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6:5], VEC[i][4]);
            @(negedge clk_i);
            check(VEC[i][3:0], $sformatf("%s vector %0d", vec_tag(i), i));
        end

        // R1: asynchronous reset mid exchange
        drive(1'b0, 1'b0, 1'b0, 2'd3, 1'b1);
        @(negedge clk_i);
        check(4'b1000, "R3 line 3 before reset");
        #1 rst_ni = 1'b0;
        #0.5;
        check(4'b0000, "R1 async reset mid exchange");
        @(negedge clk_i);
        drive(1'b0, 1'b0, 1'b0, 2'd1, 1'b1);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check(4'b0010, "R1 R3 exchange after reset on line 1");

        // R4: back-to-back exchanges leave one idle cycle
        drive(1'b0, 1'b0, 1'b0, 2'd1, 1'b0);
        @(negedge clk_i);
        check(4'b0000, "R4 gap between exchanges");
        drive(1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
        @(negedge clk_i);
        check(4'b0001, "R3 second exchange line 0");

        // R9: held exchange never shows two active lines
        for (int k = 0; k < 4; k++) begin
            drive(1'b0, 1'b0, 1'b0, 2'(k), 1'b1);
            @(negedge clk_i);
            check(4'b0001, "R9 R5 single active line while index sweeps");
        end
        drive(1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        @(negedge clk_i);
        check(4'b0000, "R4 final finish");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule